// File: doc/BRIEF.md
# Nibble Bus Memory Read Initiator

This block is the host end of a 4-bit multiplexed firmware memory bus, and it performs single-byte reads. A client presents a 4-bit target ID and a 28-bit byte address through a valid/ready handshake. The block then sends a read frame on the bus, one nibble per clock. It hands the bus over to the target, waits on the target's sync codes for as long as they say wait, takes the byte in two nibbles, and returns the bus through a two-clock turnaround. Last, it reports the byte with a one-cycle response pulse.

The bus is split into a sampled input, a driven output and an output enable. A pad ring or a bench combines them into a tri-state nibble. A separate active-low frame strobe marks the start of each frame. The response stops with an error flag when a target keeps the bus waiting too long or returns a sync code that has no meaning.

Top module: `nib_rd_init`

## Requirements
- R1: One clock after a request is accepted, the frame strobe is low for exactly one cycle. In that cycle the bus output is enabled and carries the start code 1101b.
- R2: In the following cycle the bus carries the 4-bit target ID. After the ID come the seven nibbles of the 28-bit address, most significant nibble first.
- R3: After the last address nibble, the host drives the size code 0000b for one cycle and then 1111b for one cycle. From the next cycle on, the output enable stays low until the read ends. The strobe stays high after the start cycle.
- R4: The host treats frame cycle 12 (cycle 0 is the start cycle) and every later cycle as a sync sample until it sees ready. The value 0101b means wait and the host keeps sampling. The value 0000b means ready.
- R5: The nibble in the cycle after ready is the low half of the byte, and the nibble in the cycle after that is the high half. A successful read reports rsp_data = {high, low} with rsp_err = 0.
- R6: Two turnaround cycles follow the high nibble. The rsp_valid output is a single-cycle pulse that becomes visible 17 + W clock edges after the accepting edge, where W is the number of wait syncs.
- R7: req_ready is high while idle and falls at the accepting edge. It stays low until the cycle in which the response is shown. While busy, changes on req_valid, req_id and req_addr have no effect, because ID and address are latched at acceptance.
- R8: If the sync sample after WAIT_LIMIT wait syncs is also a wait, the read is abandoned. The next cycle then shows rsp_valid = 1, rsp_err = 1 and rsp_data = 00h.
- R9: A sync sample other than 0101b or 0000b abandons the read. It gives the same error response in the next cycle.
- R10: After reset, req_ready = 1, the frame strobe is 1, the output enable is 0 and rsp_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_id | input | 4 | Target ID for the frame |
| req_addr | input | 28 | Byte address to read |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 8 | Byte read (00h on error) |
| rsp_err | output | 1 | Read abandoned (timeout or illegal sync) |
| bus_in | input | 4 | Nibble sampled from the bus |
| bus_out | output | 4 | Nibble driven onto the bus |
| bus_oe | output | 1 | Output enable for bus_out |
| bus_frame_n | output | 1 | Active-low frame start strobe |

## Verification
The assertions take two things for granted. First, the client holds req_valid until it sees req_ready. Second, bus_in matters only in sync and data cycles, so its value in host-driven cycles is treated as noise. The bench target model drives 1111b in every cycle it does not own. It returns only the legal wait and ready codes and a byte derived arithmetically from the ID and address, except in the runs that inject a bad sync code at a chosen position or stretch the wait count beyond WAIT_LIMIT. The sweep covers every ID against every legal wait count from 0 to WAIT_LIMIT.

// File: rtl/nib_rd_pkg.sv
package nib_rd_pkg;

  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] CODE_START = 4'b1101;
  localparam logic [NIB_W-1:0] CODE_SIZE1 = 4'b0000;
  localparam logic [NIB_W-1:0] CODE_TAR   = 4'b1111;
  localparam logic [NIB_W-1:0] SYNC_WAIT  = 4'b0101;
  localparam logic [NIB_W-1:0] SYNC_READY = 4'b0000;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_ID,
    S_ADDR,
    S_SIZE,
    S_HTAR0,
    S_HTAR1,
    S_SYNC,
    S_DLO,
    S_DHI,
    S_TTAR0,
    S_TTAR1
  } rd_state_t;

endpackage

// File: rtl/nib_rd_timer.sv
module nib_rd_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT));

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    expired |-> !step) else $error("wait counter stepped past its limit"); // R8

endmodule

// File: rtl/nib_rd_asm.sv
module nib_rd_asm #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               cap_lo,
  input  logic               cap_hi,
  input  logic [NIB_W-1:0]   nib,
  output logic [2*NIB_W-1:0] byte_o
);

  logic [NIB_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo) lo_q <= nib;
      if (cap_hi) hi_q <= nib;
    end
  end

  assign byte_o = {hi_q, lo_q};

  AST_LOW_BEFORE_HIGH: assert property (@(posedge clk) disable iff (rst)
    cap_hi |-> $past(cap_lo)) else $error("high nibble captured out of order"); // R5

endmodule

// File: rtl/nib_rd_seq.sv
module nib_rd_seq
  import nib_rd_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NIB_W-1:0]  req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NIB_W-1:0]  bus_in,
  output logic [NIB_W-1:0]  bus_out,
  output logic              bus_oe,
  output logic              bus_frame_n,
  output logic              tmr_clr,
  output logic              tmr_step,
  input  logic              tmr_expired,
  output logic              cap_clr,
  output logic              cap_lo,
  output logic              cap_hi,
  output logic              rsp_valid,
  output logic              rsp_err
);

  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int IDX_W     = $clog2(ADDR_NIBS);

  rd_state_t          state, st_nx;
  logic [IDX_W-1:0]   idx, idx_nx;
  logic [NIB_W-1:0]   id_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               abort;
  logic [NIB_W-1:0]   out_nx;
  logic               oe_nx;
  logic               accept;

  assign accept = (state == S_IDLE) && req_valid;

  always_comb begin
    st_nx  = state;
    idx_nx = idx;
    abort  = 1'b0;
    case (state)
      S_IDLE:  if (req_valid) st_nx = S_START;
      S_START: st_nx = S_ID;
      S_ID: begin
        st_nx  = S_ADDR;
        idx_nx = IDX_W'(ADDR_NIBS - 1);
      end
      S_ADDR:  if (idx == '0) st_nx = S_SIZE;
               else idx_nx = idx - 1'b1;
      S_SIZE:  st_nx = S_HTAR0;
      S_HTAR0: st_nx = S_HTAR1;
      S_HTAR1: st_nx = S_SYNC;
      S_SYNC: begin
        if (bus_in == SYNC_READY) st_nx = S_DLO;
        else if (bus_in != SYNC_WAIT || tmr_expired) begin
          st_nx = S_IDLE;
          abort = 1'b1;
        end
      end
      S_DLO:   st_nx = S_DHI;
      S_DHI:   st_nx = S_TTAR0;
      S_TTAR0: st_nx = S_TTAR1;
      S_TTAR1: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_comb begin
    oe_nx  = 1'b1;
    out_nx = CODE_TAR;
    case (st_nx)
      S_START: out_nx = CODE_START;
      S_ID:    out_nx = id_q;
      S_ADDR:  out_nx = addr_q[{idx_nx, 2'b00} +: NIB_W];
      S_SIZE:  out_nx = CODE_SIZE1;
      S_HTAR0: out_nx = CODE_TAR;
      default: oe_nx  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      idx         <= '0;
      id_q        <= '0;
      addr_q      <= '0;
      bus_out     <= CODE_TAR;
      bus_oe      <= 1'b0;
      bus_frame_n <= 1'b1;
      req_ready   <= 1'b1;
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
    end else begin
      state       <= st_nx;
      idx         <= idx_nx;
      if (accept) begin
        id_q   <= req_id;
        addr_q <= req_addr;
      end
      bus_out     <= out_nx;
      bus_oe      <= oe_nx;
      bus_frame_n <= (st_nx != S_START);
      req_ready   <= (st_nx == S_IDLE);
      rsp_valid   <= (state != S_IDLE) && (st_nx == S_IDLE);
      rsp_err     <= abort;
    end
  end

  assign tmr_clr  = (state != S_SYNC);
  assign tmr_step = (state == S_SYNC) && (bus_in == SYNC_WAIT) && !tmr_expired;
  assign cap_clr  = accept;
  assign cap_lo   = (state == S_DLO);
  assign cap_hi   = (state == S_DHI);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !bus_frame_n |=> bus_frame_n) else $error("frame strobe held low"); // R1
  AST_START_CODE: assert property (@(posedge clk) disable iff (rst)
    !bus_frame_n |-> (bus_oe && bus_out == CODE_START)) else $error("bad start nibble"); // R1
  AST_FLOAT_IN_TARGET_PHASE: assert property (@(posedge clk) disable iff (rst)
    (state inside {S_SYNC, S_DLO, S_DHI, S_TTAR0, S_TTAR1}) |-> !bus_oe)
    else $error("host drives bus while target owns it"); // R3
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && !bus_frame_n))
    else $error("accept did not start a frame"); // R7
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid) else $error("response longer than one cycle"); // R6
  AST_ERR_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && req_ready)) else $error("error flag outside response"); // R9

endmodule

// File: rtl/nib_rd_init.sv
module nib_rd_init
  import nib_rd_pkg::*;
#(
  parameter int ADDR_W     = 28,
  parameter int WAIT_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_id,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              rsp_err,
  input  logic [3:0]        bus_in,
  output logic [3:0]        bus_out,
  output logic              bus_oe,
  output logic              bus_frame_n
);

  logic tmr_clr, tmr_step, tmr_expired;
  logic cap_clr, cap_lo, cap_hi;

  nib_rd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_id      (req_id),
    .req_addr    (req_addr),
    .bus_in      (bus_in),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .bus_frame_n (bus_frame_n),
    .tmr_clr     (tmr_clr),
    .tmr_step    (tmr_step),
    .tmr_expired (tmr_expired),
    .cap_clr     (cap_clr),
    .cap_lo      (cap_lo),
    .cap_hi      (cap_hi),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err)
  );

  nib_rd_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .step    (tmr_step),
    .expired (tmr_expired)
  );

  nib_rd_asm #(.NIB_W(NIB_W)) u_asm (
    .clk    (clk),
    .rst    (rst),
    .clr    (cap_clr),
    .cap_lo (cap_lo),
    .cap_hi (cap_hi),
    .nib    (bus_in),
    .byte_o (rsp_data)
  );

  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_data == 8'h00)) else $error("error response carries data"); // R8

endmodule

// File: tb/nib_rd_init_test.sv
`timescale 1ns/1ps
module nib_rd_init_test;

  localparam int LIM = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_id = '0;
  logic [27:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        rsp_err;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic        bus_frame_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  nib_rd_init #(.ADDR_W(28), .WAIT_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_frame_n(bus_frame_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R6 watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // w: wait syncs before ready; bad_at: sync index replaced by bad_val (-1 none)
  task automatic run_read(input logic [3:0] id, input logic [27:0] addr, input int w,
                          input int bad_at, input logic [3:0] bad_val, input bit hold);
    int done_c;
    bit exp_err;
    logic [7:0] exp_d;
    int frame_bad = 0;
    int ready_bad = 0;
    int early = 0;
    exp_d = addr[7:0] ^ addr[27:20] ^ {id, ~id};
    if (bad_at >= 0 && bad_at <= w && bad_at <= LIM) begin
      done_c = 13 + bad_at; exp_err = 1'b1;
    end else if (w > LIM) begin
      done_c = 13 + LIM; exp_err = 1'b1;
    end else begin
      done_c = 17 + w; exp_err = 1'b0;
    end
    @(negedge clk);
    chk(req_ready === 1'b1, "R7 ready before request", req_ready, 1);
    req_valid = 1'b1; req_id = id; req_addr = addr;
    @(posedge clk);
    for (int c = 0; c <= done_c; c++) begin
      logic [3:0] eo;
      bit eoe;
      bit efn;
      int j;
      @(negedge clk);
      if (hold) begin req_id = ~id; req_addr = ~addr; end
      else if (c == 0) req_valid = 1'b0;
      if (c <= 11) begin
        efn = (c != 0);
        eoe = (c <= 10);
        if (c == 0)      eo = 4'b1101;
        else if (c == 1) eo = id;
        else if (c <= 8) eo = addr[4*(8-c) +: 4];
        else if (c == 9) eo = 4'b0000;
        else             eo = 4'b1111;
        if (bus_frame_n !== efn || bus_oe !== eoe || (eoe && bus_out !== eo)) frame_bad++;
      end else if (bus_oe !== 1'b0 || bus_frame_n !== 1'b1) frame_bad++;
      if (c < done_c) begin
        if (req_ready !== 1'b0) ready_bad++;
        if (rsp_valid !== 1'b0) early++;
      end
      bus_in = 4'hF;
      if (c >= 12) begin
        j = c - 12;
        if (j == bad_at)      bus_in = bad_val;
        else if (j < w)       bus_in = 4'h5;
        else if (j == w)      bus_in = 4'h0;
        else if (j == w + 1)  bus_in = exp_d[3:0];
        else if (j == w + 2)  bus_in = exp_d[7:4];
      end
    end
    if (hold) req_valid = 1'b0;
    chk(frame_bad == 0, "R1 R2 R3 frame fields", frame_bad, 0);
    chk(ready_bad == 0, "R7 ready low while busy", ready_bad, 0);
    chk(early == 0 && rsp_valid === 1'b1, "R6 R4 response cycle", {early[15:0], 15'd0, rsp_valid}, 1);
    if (exp_err) begin
      chk(rsp_err === 1'b1, (w > LIM) ? "R8 timeout flag" : "R9 bad sync flag", rsp_err, 1);
      chk(rsp_data === 8'h00, "R8 error data", rsp_data, 0);
    end else begin
      chk(rsp_err === 1'b0, "R5 error clear", rsp_err, 0);
      chk(rsp_data === exp_d, "R5 data byte", rsp_data, exp_d);
    end
    chk(req_ready === 1'b1, "R7 ready at response", req_ready, 1);
    bus_in = 4'hF;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && bus_frame_n === 1'b1, "R6 R7 single pulse, no restart",
        {rsp_valid, bus_frame_n}, 2'b01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready === 1'b1 && bus_frame_n === 1'b1 && bus_oe === 1'b0 && rsp_valid === 1'b0,
        "R10 reset state", {req_ready, bus_frame_n, bus_oe, rsp_valid}, 4'b1100);

    for (int id = 0; id < 16; id++) begin
      for (int w = 0; w <= LIM; w++) begin
        run_read(4'(id), 28'(id * 32'h0123457 + w * 32'h00F1E2D3 + 32'h0A5C3), w, -1, 4'h0, 1'b0);
      end
    end

    run_read(4'h3, 28'h89ABCDE, LIM + 1, -1, 4'h0, 1'b0);   // R8 one wait too many
    run_read(4'hC, 28'h1357BDF, LIM + 4, -1, 4'h0, 1'b0);   // R8 long stall
    run_read(4'h5, 28'h2468ACE, 5, 0, 4'h1, 1'b0);          // R9 bad first sync
    run_read(4'h6, 28'hFEDCBA9, 5, 3, 4'hF, 1'b0);          // R9 bad mid sync
    run_read(4'h7, 28'h0F0F0F0, 5, 5, 4'h6, 1'b0);          // R9 bad in place of ready
    run_read(4'hA, 28'h5A5A5A5, 3, -1, 4'h0, 1'b1);         // R7 inputs changed while busy
    run_read(4'h1, 28'h0000001, 0, -1, 4'h0, 1'b0);         // R5 after errors

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule